// File: doc/BRIEF.md
# Port Pin Mode Resolver with Analog Line Routing

This block holds the configuration of an eight-pin general-purpose port and decides, pin by pin, which of three uses drives the pad. A pin can be plain digital I/O, it can carry a dedicated peripheral signal, or it can be switched into analog mode. In analog mode the pin is routed onto one of four shared analog lines. Analog mode always wins over the peripheral function, and the peripheral function always wins over plain digital I/O. After reset every pin is a digital input.

Analog mode is switched on per pair of pins. In that mode the digital driver and the pull-up are forced off, and the pull-up, output and direction bits take on new meanings. The pull-up bit of a pin closes its connection to the analog lines. The two line-select bits of an odd pin come from the output register, and those of an even pin come from the direction register. For each pin the block drives a four-bit switch control that is either one-hot or all zero.

Software reaches the registers over a byte-wide bus. The bus has an address, a write strobe and a combinational read-data path. A separate configuration reset input clears only the analog-enable bits.

Top module: `portmux_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every register reads 0x00. Every `pad_oe`, `pad_do`, `pad_pu` and `ana_sw` bit is also 0.
- R2: A pin whose pair is not analog and whose function-enable bit is 0 takes `pad_oe` from its direction bit (1 = drive), `pad_do` from its output bit and `pad_pu` from its pull-up bit.
- R3: A pin whose pair is not analog and whose function-enable bit is 1 takes `pad_oe` from `fn_oe[i]` and `pad_do` from `fn_do[i]`. Its `pad_pu` still follows its pull-up bit.
- R4: Analog-enable bit k puts pins 2k and 2k+1 into analog mode. In analog mode `pad_oe`, `pad_do` and `pad_pu` are 0 for those pins, whatever the function, direction, output and pull-up bits hold.
- R5: An analog pin whose pull-up bit is 0 has all four of its `ana_sw` bits at 0.
- R6: An analog pin whose pull-up bit is 1 closes the switch for line n, which is bit `ana_sw[4*i+n]`. For odd pin 2k+1, n is output-register bits [2k+1:2k]. For even pin 2k, n is direction-register bits [2k+1:2k].
- R7: The analog-enable register (address 4) holds four bits in positions [3:0]. Bits [7:4] always read 0, even after 0xFF is written to it.
- R8: While `cfg_rst` is high, the analog-enable bits are cleared at the next clock edge. This takes precedence over a write in the same cycle. The other registers keep their values.
- R9: The register map is: 0 pull-up, 1 output, 2 direction, 3 function-enable, 4 analog-enable, 5 pin input. Address 5 returns `pin_in` and ignores writes. Addresses 6 and 7 read 0.
- R10: Each pin's four `ana_sw` bits are never more than one-hot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of all registers |
| cfg_rst | input | 1 | Synchronous clear of the analog-enable bits only |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Pad input levels |
| fn_oe | input | 8 | Per-pin output enable from the dedicated peripheral |
| fn_do | input | 8 | Per-pin output data from the dedicated peripheral |
| pad_oe | output | 8 | Pad output enable |
| pad_do | output | 8 | Pad output data |
| pad_pu | output | 8 | Pad pull-up enable |
| ana_sw | output | 32 | Analog switch controls, pin i in bits [4i+3:4i], bit n = line n |

## Verification
A wrong mode decision inside a pin shows on that pin's `pad_oe`, `pad_do`, `pad_pu` or `ana_sw` within the same cycle, because resolution is purely combinational from the registers. A write that lands in the wrong register, or a bad clear, shows one cycle after the write. It is visible both at the pads and through a readback of the same address. The vector table pairs every mode with register contents that would give a different result under any other mode, so a swapped priority or a swapped select source changes at least one output bit.

// File: rtl/portmux_pkg.sv
package portmux_pkg;

    localparam int PORT_PINS = 8;
    localparam int ANA_LINES = 4;
    localparam int PINS_PER_GRP = 2;
    localparam int ANA_GRPS = PORT_PINS / PINS_PER_GRP;
    localparam int SEL_W = $clog2(ANA_LINES);
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_DIO  = 2'd0,
        MODE_FUNC = 2'd1,
        MODE_ANA  = 2'd2
    } pin_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        ADR_PULL = 3'd0,
        ADR_OUT  = 3'd1,
        ADR_DIR  = 3'd2,
        ADR_FUNC = 3'd3,
        ADR_ANA  = 3'd4,
        ADR_PIN  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [PORT_PINS-1:0] pull;
        logic [PORT_PINS-1:0] dout;
        logic [PORT_PINS-1:0] dir;
        logic [PORT_PINS-1:0] fn_en;
        logic [ANA_GRPS-1:0]  ana_en;
    } port_cfg_t;

    typedef struct packed {
        logic                 oe;
        logic                 dout;
        logic                 pu;
        logic [ANA_LINES-1:0] sw;
    } pin_drive_t;

    function automatic pin_mode_e resolve_mode(input logic ana, input logic fn);
        if (ana)     return MODE_ANA;
        else if (fn) return MODE_FUNC;
        else         return MODE_DIO;
    endfunction

endpackage

// File: rtl/portmux_regs.sv
module portmux_regs
    import portmux_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [PORT_PINS-1:0] pin_in,
    output port_cfg_t            cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    ADR_PULL: cfg.pull   <= bus_wdata[PORT_PINS-1:0];
                    ADR_OUT:  cfg.dout   <= bus_wdata[PORT_PINS-1:0];
                    ADR_DIR:  cfg.dir    <= bus_wdata[PORT_PINS-1:0];
                    ADR_FUNC: cfg.fn_en  <= bus_wdata[PORT_PINS-1:0];
                    ADR_ANA:  cfg.ana_en <= bus_wdata[ANA_GRPS-1:0];
                    default: ;
                endcase
            end
            // configuration clear wins over a same-cycle write
            if (cfg_rst) cfg.ana_en <= '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_PULL: bus_rdata[PORT_PINS-1:0] = cfg.pull;
            ADR_OUT:  bus_rdata[PORT_PINS-1:0] = cfg.dout;
            ADR_DIR:  bus_rdata[PORT_PINS-1:0] = cfg.dir;
            ADR_FUNC: bus_rdata[PORT_PINS-1:0] = cfg.fn_en;
            ADR_ANA:  bus_rdata[ANA_GRPS-1:0]  = cfg.ana_en;
            ADR_PIN:  bus_rdata[PORT_PINS-1:0] = pin_in;
            default:  bus_rdata = '0;
        endcase
    end

    // R8
    cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rst |=> (bus_addr != ADR_ANA || bus_rdata == '0));

    // R7
    ana_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADR_ANA) |-> (bus_rdata[DATA_W-1:ANA_GRPS] == '0));

    // R9
    pin_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADR_PIN) |-> (bus_rdata[PORT_PINS-1:0] == pin_in));

endmodule

// File: rtl/portmux_pin.sv
module portmux_pin
    import portmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ana_en,
    input  logic             fn_en,
    input  logic             dir_bit,
    input  logic             out_bit,
    input  logic             pull_bit,
    input  logic [SEL_W-1:0] line_sel,
    input  logic             fn_oe,
    input  logic             fn_do,
    output pin_drive_t       drv
);

    pin_mode_e mode;

    always_comb begin
        mode = resolve_mode(ana_en, fn_en);
        drv  = '0;
        unique case (mode)
            MODE_ANA: begin
                if (pull_bit) drv.sw[line_sel] = 1'b1;
            end
            MODE_FUNC: begin
                drv.oe   = fn_oe;
                drv.dout = fn_do;
                drv.pu   = pull_bit;
            end
            default: begin
                drv.oe   = dir_bit;
                drv.dout = out_bit;
                drv.pu   = pull_bit;
            end
        endcase
    end

    // R4
    ana_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ana_en |-> (!drv.oe && !drv.dout && !drv.pu));

    // R5
    ana_open_chk: assert property (@(posedge clk) disable iff (rst)
        (ana_en && !pull_bit) |-> (drv.sw == '0));

    // R10
    sw_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv.sw));

    // R2
    dio_sw_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ana_en |-> (drv.sw == '0));

endmodule

// File: rtl/portmux_top.sv
module portmux_top
    import portmux_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_rst,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [PORT_PINS-1:0]           pin_in,
    input  logic [PORT_PINS-1:0]           fn_oe,
    input  logic [PORT_PINS-1:0]           fn_do,
    output logic [PORT_PINS-1:0]           pad_oe,
    output logic [PORT_PINS-1:0]           pad_do,
    output logic [PORT_PINS-1:0]           pad_pu,
    output logic [PORT_PINS*ANA_LINES-1:0] ana_sw
);

    port_cfg_t cfg;

    portmux_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_rst   (cfg_rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .cfg       (cfg)
    );

    for (genvar i = 0; i < PORT_PINS; i++) begin : g_pin
        localparam int GRP = i / PINS_PER_GRP;
        logic [SEL_W-1:0] sel;
        pin_drive_t       drv;

        // odd pins select from the output register, even pins from direction
        if (i % 2 == 1) begin : g_odd
            assign sel = cfg.dout[GRP*PINS_PER_GRP +: SEL_W];
        end else begin : g_even
            assign sel = cfg.dir[GRP*PINS_PER_GRP +: SEL_W];
        end

        portmux_pin i_pin (
            .clk      (clk),
            .rst      (rst),
            .ana_en   (cfg.ana_en[GRP]),
            .fn_en    (cfg.fn_en[i]),
            .dir_bit  (cfg.dir[i]),
            .out_bit  (cfg.dout[i]),
            .pull_bit (cfg.pull[i]),
            .line_sel (sel),
            .fn_oe    (fn_oe[i]),
            .fn_do    (fn_do[i]),
            .drv      (drv)
        );

        assign pad_oe[i] = drv.oe;
        assign pad_do[i] = drv.dout;
        assign pad_pu[i] = drv.pu;
        assign ana_sw[i*ANA_LINES +: ANA_LINES] = drv.sw;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_pu == '0 && ana_sw == '0));

endmodule

// File: tb/test_portmux_top.sv
module test_portmux_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_rst = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = 8'h00;
    logic [7:0]  fn_oe = '0;
    logic [7:0]  fn_do = '0;
    logic [7:0]  pad_oe, pad_do, pad_pu;
    logic [31:0] ana_sw;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    portmux_top i_portmux_top (
        .clk(clk), .rst(rst), .cfg_rst(cfg_rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .fn_oe(fn_oe), .fn_do(fn_do),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .ana_sw(ana_sw)
    );

    // pull, out, dir, func, ana, fn_oe, fn_do | exp oe, do, pu, sw
    typedef struct packed {
        logic [7:0]  pull, dout, dir, fn, ana, foe, fdo;
        logic [7:0]  e_oe, e_do, e_pu;
        logic [31:0] e_sw;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        // R2 digital
        '{8'hA5, 8'h3C, 8'h0F, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h3C, 8'hA5, 32'h0000_0000},
        // R3 function on upper pins
        '{8'h00, 8'h00, 8'h00, 8'hF0, 8'h00, 8'hCC, 8'hAA, 8'hC0, 8'hA0, 8'h00, 32'h0000_0000},
        // R4 R6 analog pairs 0 and 3, others digital
        '{8'hFF, 8'hDA, 8'h64, 8'h00, 8'h09, 8'h00, 8'h00, 8'h24, 8'h18, 8'h3C, 32'h8200_0041},
        // R4 R5 R6 analog pairs 1 and 2 over enabled functions
        '{8'h24, 8'hFF, 8'h00, 8'hFF, 8'h06, 8'hFF, 8'hFF, 8'hC3, 8'hC3, 8'h00, 32'h0080_0100}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 outputs during reset
        check("R1", {pad_oe, pad_do, pad_pu}, 24'h0);
        check("R1", ana_sw, 32'h0);
        rst = 1'b0;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            check("R1", {24'h0, r}, 32'h0);
        end

        for (int v = 0; v < NV; v++) begin
            wr(3'd0, VECS[v].pull);
            wr(3'd1, VECS[v].dout);
            wr(3'd2, VECS[v].dir);
            wr(3'd3, VECS[v].fn);
            wr(3'd4, VECS[v].ana);
            fn_oe = VECS[v].foe;
            fn_do = VECS[v].fdo;
            @(negedge clk);
            check("R2 R3 R4 pad_oe", {24'h0, pad_oe}, {24'h0, VECS[v].e_oe});
            check("R2 R3 R4 pad_do", {24'h0, pad_do}, {24'h0, VECS[v].e_do});
            check("R2 R3 R4 pad_pu", {24'h0, pad_pu}, {24'h0, VECS[v].e_pu});
            check("R5 R6 ana_sw", ana_sw, VECS[v].e_sw);
        end

        // R7 upper analog-enable bits
        wr(3'd4, 8'hFF);
        rd(3'd4, r);
        check("R7", {24'h0, r}, 32'h0F);

        // R8 configuration clear: analog bits only, wins over a write
        wr(3'd0, 8'h5A);
        @(negedge clk);
        cfg_rst = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h0F; bus_wr = 1'b1;
        @(negedge clk);
        cfg_rst = 1'b0; bus_wr = 1'b0;
        rd(3'd4, r);
        check("R8 ana cleared", {24'h0, r}, 32'h0);
        rd(3'd0, r);
        check("R8 pull kept", {24'h0, r}, 32'h5A);

        // R9 pin input read, write ignored, spare addresses
        pin_in = 8'h96;
        rd(3'd5, r);
        check("R9 pin read", {24'h0, r}, 32'h96);
        wr(3'd5, 8'hFF);
        rd(3'd5, r);
        check("R9 pin write ignored", {24'h0, r}, 32'h96);
        rd(3'd0, r);
        check("R9 pull after addr5 write", {24'h0, r}, 32'h5A);
        rd(3'd6, r);
        check("R9 addr6", {24'h0, r}, 32'h0);
        rd(3'd7, r);
        check("R9 addr7", {24'h0, r}, 32'h0);

        // R10 sweep one analog pin pair over all line codes
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h03);
        wr(3'd4, 8'h01);
        for (int s = 0; s < 4; s++) begin
            wr(3'd1, 8'(s));
            wr(3'd2, 8'(3 - s));
            @(negedge clk);
            check("R10 R6 sweep", ana_sw, {24'h0, 4'(1 << s), 4'(1 << (3 - s))});
        end

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 after reset", {8'h0, pad_oe, pad_pu, 8'h0}, 32'h0);
        check("R1 after reset sw", ana_sw, 32'h0);
        rd(3'd4, r);
        check("R1 ana reg", {24'h0, r}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule